// File: doc/BRIEF.md
# Extracode Trap and Mode Sequencer

This block sits at the front of an instruction pipeline that uses 48-bit words. It looks at the function field of each instruction. Ordinary operations are handed to the hardware execution path. Extracode operations become subroutine entries into read-only fixed store, where each of the 512 possible codes has its own entry point.

The block owns a 128-entry index-register file. Three of its top entries serve as private program counters, one each for user, extracode and supervisor mode, so a mode change only switches which register drives the fetch address. Nothing is saved or restored. On each extracode entry the modified operand address is captured so that the trap routine can pick it up. An interrupt request forces supervisor mode. A return request leaves the current mode and goes back to the mode that was left.

Top module: `xc_trap_seq`

## Requirements
- R1: Register 0 always reads as zero, and writes to it from the write port have no visible effect.
- R2: An instruction whose function bit 9 (word bit 47) is 0 is ordinary. In the next cycle `hw_valid` is 1 and `hw_op` equals function bits 8..0. The active program counter advances by one and the mode does not change. Word layout: function [47:38], first index field [37:31], second index field [30:24], address [23:0].
- R3: An instruction whose function bit 9 is 1 is an extracode. In the next cycle the mode is extracode (encoding 1), `xc_taken` is 1, `hw_valid` is 0, and register 126 (the active PC) holds XBASE + code × XSTRIDE. With the defaults this is 0x800000 + 4 × code.
- R4: On extracode entry, `xc_opnd` is loaded with address + reg[first index] + reg[second index], modulo 2^24.
- R5: An extracode advances the program counter of the mode that issued it by one, which leaves that mode's return point.
- R6: A return request in extracode mode goes back to the mode that was active when the extracode chain began. A chained extracode keeps the original return mode.
- R7: An interrupt request outside supervisor mode wins over an instruction presented in the same cycle. The mode becomes supervisor (encoding 2) and the instruction is discarded: no PC change, no `hw_valid`, no `xc_taken`.
- R8: A return request in supervisor mode goes back to the mode that was interrupted.
- R9: Register 127, the user PC, never changes while the mode is extracode or supervisor. This includes write-port writes to it.
- R10: `pc` shows register 127 in user mode (encoding 0), register 126 in extracode mode and register 125 in supervisor mode.
- R11: An interrupt request in supervisor mode, or a return request in user mode, has no effect.
- R12: After reset the mode is user, every register reads zero, and `hw_valid`, `xc_taken` and `xc_opnd` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction is presented |
| instr | input | 48 | Instruction word |
| irq | input | 1 | Interrupt request |
| ret_req | input | 1 | Return from the current trap mode |
| wr_en | input | 1 | Register write strobe from the execution path |
| wr_idx | input | 7 | Register write index |
| wr_data | input | 24 | Register write data |
| rd_idx | input | 7 | Register read index |
| rd_data | output | 24 | Register read data (combinational) |
| mode | output | 2 | Active mode: 0 user, 1 extracode, 2 supervisor |
| pc | output | 24 | Program counter of the active mode |
| hw_valid | output | 1 | Ordinary operation issued last cycle |
| hw_op | output | 9 | Opcode of the issued ordinary operation |
| xc_taken | output | 1 | Extracode entry taken last cycle |
| xc_opnd | output | 24 | Operand address captured at the last extracode entry |

## Verification
The bench sweeps all 512 ordinary codes and all 512 extracode codes. A design that decoded the wrong function bit, or that scaled or offset the entry vector incorrectly, would miss on some code. A design that got the index modification wrong would put a wrong operand address in `xc_opnd`, and the bench also drives that sum past 2^24 to check that it wraps. The harder cases are the priority and nesting rules. The bench presents an interrupt together with an extracode, which a wrong design would let trap or advance a PC. It tries to write the user PC from inside a trap, which a leaky design would let through. It interrupts an extracode routine and chains an extracode from supervisor mode, and a design with a single return state would then come back to the wrong mode or the wrong PC.

// File: rtl/xts_pkg.sv
package xts_pkg;
  typedef enum logic [1:0] {
    MODE_USR = 2'd0,
    MODE_XC  = 2'd1,
    MODE_SUP = 2'd2
  } mode_e;
endpackage

// File: rtl/xts_decode.sv
module xts_decode #(
  parameter int IW = 7,
  parameter int AW = 24,
  parameter int FW = 10,
  localparam int WW = FW + 2 * IW + AW
) (
  input  logic [WW-1:0] word,
  output logic          is_xc,
  output logic [FW-2:0] code,
  output logic [IW-1:0] ba,
  output logic [IW-1:0] bm,
  output logic [AW-1:0] addr
);
  assign is_xc = word[WW-1];
  assign code  = word[WW-2 -: FW-1];
  assign ba    = word[AW+2*IW-1 -: IW];
  assign bm    = word[AW+IW-1 -: IW];
  assign addr  = word[AW-1:0];
endmodule

// File: rtl/xts_regfile.sv
module xts_regfile #(
  parameter int NREG = 128,
  parameter int IW   = 7,
  parameter int AW   = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_we,
  input  logic [IW-1:0] a_idx,
  input  logic [AW-1:0] a_val,
  input  logic          b_we,
  input  logic [IW-1:0] b_idx,
  input  logic [AW-1:0] b_val,
  input  logic          e_we,
  input  logic [IW-1:0] e_idx,
  input  logic [AW-1:0] e_val,
  input  logic [IW-1:0] pc_idx,
  output logic [AW-1:0] pc_data,
  input  logic [IW-1:0] ba_idx,
  output logic [AW-1:0] ba_data,
  input  logic [IW-1:0] bm_idx,
  output logic [AW-1:0] bm_data,
  input  logic [IW-1:0] rd_idx,
  output logic [AW-1:0] rd_data,
  output logic [AW-1:0] upc_q
);
  logic [AW-1:0] mem [NREG];

  // entry 0 is cleared by reset and excluded from every write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else begin
      for (int i = 1; i < NREG; i++) begin
        if (b_we && b_idx == IW'(i))      mem[i] <= b_val;
        else if (a_we && a_idx == IW'(i)) mem[i] <= a_val;
        else if (e_we && e_idx == IW'(i)) mem[i] <= e_val;
      end
    end
  end

  assign pc_data = mem[pc_idx];
  assign ba_data = mem[ba_idx];
  assign bm_data = mem[bm_idx];
  assign rd_data = mem[rd_idx];
  assign upc_q   = mem[NREG-1];
endmodule

// File: rtl/xts_mode_ctl.sv
module xts_mode_ctl
  import xts_pkg::*;
#(
  parameter int          NREG    = 128,
  parameter int          IW      = 7,
  parameter int          AW      = 24,
  parameter int          CW      = 9,
  parameter logic [23:0] XBASE   = 24'h800000,
  parameter logic [23:0] XSTRIDE = 24'd4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  input  logic          is_xc,
  input  logic [CW-1:0] code,
  input  logic          irq,
  input  logic          ret_req,
  input  logic [AW-1:0] pc_cur,
  input  logic [AW-1:0] opnd_in,
  output mode_e         mode_q,
  output logic [IW-1:0] pc_idx,
  output logic          a_we,
  output logic [AW-1:0] a_val,
  output logic          b_we,
  output logic [AW-1:0] b_val,
  output logic          hw_valid,
  output logic [CW-1:0] hw_op,
  output logic          xc_taken,
  output logic [AW-1:0] xc_opnd,
  output logic          act_irq,
  output logic          act_ret,
  output logic          act_hw,
  output logic          act_xc
);
  localparam logic [IW-1:0] UPC_IDX = IW'(NREG - 1);
  localparam logic [IW-1:0] XPC_IDX = IW'(NREG - 2);
  localparam logic [IW-1:0] SPC_IDX = IW'(NREG - 3);

  mode_e xc_back_q, sup_back_q, mode_d;

  function automatic logic [AW-1:0] entry_of(input logic [CW-1:0] c);
    return AW'(XBASE) + AW'(c) * AW'(XSTRIDE);
  endfunction

  // priority: interrupt, return, instruction
  assign act_irq = irq && (mode_q != MODE_SUP);
  assign act_ret = !act_irq && ret_req && (mode_q != MODE_USR);
  assign act_hw  = !act_irq && !act_ret && instr_valid && !is_xc;
  assign act_xc  = !act_irq && !act_ret && instr_valid && is_xc;

  always_comb begin
    case (mode_q)
      MODE_XC:  pc_idx = XPC_IDX;
      MODE_SUP: pc_idx = SPC_IDX;
      default:  pc_idx = UPC_IDX;
    endcase
  end

  // port a advances the issuing PC, port b loads the trap vector (wins)
  assign a_we  = act_hw || act_xc;
  assign a_val = pc_cur + AW'(1);
  assign b_we  = act_xc;
  assign b_val = entry_of(code);

  always_comb begin
    mode_d = mode_q;
    if (act_irq)                         mode_d = MODE_SUP;
    else if (act_ret && mode_q == MODE_XC) mode_d = xc_back_q;
    else if (act_ret)                    mode_d = sup_back_q;
    else if (act_xc)                     mode_d = MODE_XC;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= MODE_USR;
      xc_back_q  <= MODE_USR;
      sup_back_q <= MODE_USR;
      hw_valid   <= 1'b0;
      hw_op      <= '0;
      xc_taken   <= 1'b0;
      xc_opnd    <= '0;
    end else begin
      mode_q   <= mode_d;
      hw_valid <= act_hw;
      xc_taken <= act_xc;
      if (act_hw) hw_op <= code;
      if (act_irq) sup_back_q <= mode_q;
      if (act_xc) begin
        xc_opnd <= opnd_in;
        if (mode_q != MODE_XC) xc_back_q <= mode_q;
      end
    end
  end
endmodule

// File: rtl/xc_trap_seq.sv
module xc_trap_seq
  import xts_pkg::*;
#(
  parameter int          NREG    = 128,
  parameter int          AW      = 24,
  parameter int          FW      = 10,
  parameter logic [23:0] XBASE   = 24'h800000,
  parameter logic [23:0] XSTRIDE = 24'd4,
  localparam int         IW      = $clog2(NREG),
  localparam int         CW      = FW - 1,
  localparam int         WW      = FW + 2 * IW + AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  input  logic [WW-1:0] instr,
  input  logic          irq,
  input  logic          ret_req,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [AW-1:0] rd_data,
  output logic [1:0]    mode,
  output logic [AW-1:0] pc,
  output logic          hw_valid,
  output logic [CW-1:0] hw_op,
  output logic          xc_taken,
  output logic [AW-1:0] xc_opnd
);
  localparam logic [IW-1:0] UPC_IDX = IW'(NREG - 1);
  localparam logic [IW-1:0] XPC_IDX = IW'(NREG - 2);

  function automatic logic [AW-1:0] modify(input logic [AW-1:0] a,
                                           input logic [AW-1:0] x,
                                           input logic [AW-1:0] y);
    return a + x + y;
  endfunction

  logic          is_xc;
  logic [CW-1:0] code;
  logic [IW-1:0] ba, bm, pc_idx;
  logic [AW-1:0] addr, ba_data, bm_data, opnd, upc_val, a_val, b_val;
  logic          a_we, b_we, e_we;
  logic          act_irq, act_ret, act_hw, act_xc;
  mode_e         mode_q;

  xts_decode #(.IW(IW), .AW(AW), .FW(FW)) u_dec (
    .word(instr), .is_xc(is_xc), .code(code), .ba(ba), .bm(bm), .addr(addr)
  );

  assign opnd = modify(addr, ba_data, bm_data);
  // the user PC may be written from outside only while user mode runs
  assign e_we = wr_en && !(wr_idx == UPC_IDX && mode_q != MODE_USR);

  xts_mode_ctl #(.NREG(NREG), .IW(IW), .AW(AW), .CW(CW),
                 .XBASE(XBASE), .XSTRIDE(XSTRIDE)) u_ctl (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .is_xc(is_xc),
    .code(code), .irq(irq), .ret_req(ret_req), .pc_cur(pc), .opnd_in(opnd),
    .mode_q(mode_q), .pc_idx(pc_idx), .a_we(a_we), .a_val(a_val),
    .b_we(b_we), .b_val(b_val), .hw_valid(hw_valid), .hw_op(hw_op),
    .xc_taken(xc_taken), .xc_opnd(xc_opnd), .act_irq(act_irq),
    .act_ret(act_ret), .act_hw(act_hw), .act_xc(act_xc)
  );

  xts_regfile #(.NREG(NREG), .IW(IW), .AW(AW)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .a_we(a_we), .a_idx(pc_idx), .a_val(a_val),
    .b_we(b_we), .b_idx(XPC_IDX), .b_val(b_val),
    .e_we(e_we), .e_idx(wr_idx), .e_val(wr_data),
    .pc_idx(pc_idx), .pc_data(pc), .ba_idx(ba), .ba_data(ba_data),
    .bm_idx(bm), .bm_data(bm_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .upc_q(upc_val)
  );

  assign mode = mode_q;
endmodule

// File: rtl/xts_chk.sv
module xts_chk #(
  parameter int AW = 24,
  parameter int IW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic [AW-1:0] pc,
  input logic [AW-1:0] upc,
  input logic          hw_valid,
  input logic          xc_taken,
  input logic          act_irq,
  input logic          act_hw,
  input logic          act_xc,
  input logic [IW-1:0] rd_idx,
  input logic [AW-1:0] rd_data
);
  // R1
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == '0) |-> (rd_data == '0));
  // R2
  hw_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_hw |=> (hw_valid && !xc_taken && $stable(mode)));
  // R3
  xc_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_xc |=> (mode == 2'd1 && xc_taken && !hw_valid));
  // R7
  irq_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_irq |=> (mode == 2'd2 && !hw_valid && !xc_taken));
  // R9
  upc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd0) |=> $stable(upc));
  // R10
  pc_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |-> (pc == upc));
endmodule

bind xc_trap_seq xts_chk #(.AW(AW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .pc(pc), .upc(upc_val),
  .hw_valid(hw_valid), .xc_taken(xc_taken), .act_irq(act_irq),
  .act_hw(act_hw), .act_xc(act_xc), .rd_idx(rd_idx), .rd_data(rd_data)
);

// File: tb/xc_trap_seq_tb.sv
`timescale 1ns/1ps
module xc_trap_seq_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        instr_valid = 1'b0, irq = 1'b0, ret_req = 1'b0, wr_en = 1'b0;
  logic [47:0] instr = '0;
  logic [6:0]  wr_idx = '0, rd_idx = '0;
  logic [23:0] wr_data = '0, rd_data, pc, xc_opnd;
  logic [1:0]  mode;
  logic        hw_valid, xc_taken;
  logic [8:0]  hw_op;
  int n_chk = 0, n_bad = 0;
  logic [23:0] u_exp, v;

  always #2 clk = ~clk;

  xc_trap_seq u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .irq(irq), .ret_req(ret_req), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .mode(mode),
    .pc(pc), .hw_valid(hw_valid), .hw_op(hw_op), .xc_taken(xc_taken),
    .xc_opnd(xc_opnd)
  );

  function automatic logic [23:0] vec(int c);
    return 24'h800000 | 24'(c << 2);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic issue(logic [9:0] f, logic [6:0] a, logic [6:0] m, logic [23:0] ad);
    instr = {f, a, m, ad}; instr_valid = 1'b1; cyc(); instr_valid = 1'b0;
  endtask

  task automatic wreg(logic [6:0] i, logic [23:0] d);
    wr_idx = i; wr_data = d; wr_en = 1'b1; cyc(); wr_en = 1'b0;
  endtask

  task automatic rreg(logic [6:0] i, output logic [23:0] d);
    rd_idx = i; #0.5; d = rd_data;
  endtask

  task automatic do_ret();
    ret_req = 1'b1; cyc(); ret_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4ns * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    // R12 reset state
    chk("R12 mode", mode, 0); chk("R12 pc", pc, 0);
    chk("R12 hw_valid", hw_valid, 0); chk("R12 xc_taken", xc_taken, 0);
    chk("R12 xc_opnd", xc_opnd, 0);
    rreg(7'd125, v); chk("R12 reg125", v, 0);
    // R1 register zero
    wreg(7'd0, 24'hABCDEF); rreg(7'd0, v); chk("R1 reg0", v, 0);
    wreg(7'd5, 24'h000123); rreg(7'd5, v); chk("R1 reg5 control", v, 24'h123);
    wreg(7'd127, 24'h000100); u_exp = 24'h100;
    chk("R10 user pc", pc, u_exp);
    // R2 sweep all ordinary codes
    for (int c = 0; c < 512; c++) begin
      issue({1'b0, 9'(c)}, 7'd0, 7'd0, 24'h0); u_exp = u_exp + 1;
      chk("R2 hw_valid", hw_valid, 1); chk("R2 hw_op", hw_op, c);
      chk("R2 pc", pc, u_exp); chk("R2 mode", mode, 0);
    end
    // R3 R4 R5 R6 sweep all extracode codes
    for (int c = 0; c < 512; c++) begin
      wreg(7'd5, 24'(c * 7)); wreg(7'd9, 24'(c * 3));
      issue({1'b1, 9'(c)}, 7'd9, 7'd5, 24'h0F0000 + 24'(c)); u_exp = u_exp + 1;
      chk("R3 mode", mode, 1); chk("R3 xc_taken", xc_taken, 1);
      chk("R3 hw_valid", hw_valid, 0); chk("R3 vector", pc, vec(c));
      chk("R4 operand", xc_opnd, 24'h0F0000 + 24'(c * 11));
      rreg(7'd127, v); chk("R5 user return point", v, u_exp);
      do_ret(); chk("R6 mode", mode, 0); chk("R6 pc", pc, u_exp);
    end
    // R9 user PC frozen inside a trap
    issue(10'h203, 7'd0, 7'd0, 24'h0); u_exp = u_exp + 1;
    wreg(7'd127, 24'h000777); rreg(7'd127, v); chk("R9 blocked write", v, u_exp);
    issue(10'h011, 7'd0, 7'd0, 24'h0);
    chk("R10 xc pc advance", pc, vec(3) + 1);
    rreg(7'd127, v); chk("R9 after xc op", v, u_exp);
    do_ret(); chk("R6 back to user", pc, u_exp);
    // R7 interrupt beats extracode
    wreg(7'd125, 24'h005000);
    irq = 1'b1; issue(10'h205, 7'd0, 7'd0, 24'h0); irq = 1'b0;
    chk("R7 mode", mode, 2); chk("R7 xc_taken", xc_taken, 0);
    chk("R7 hw_valid", hw_valid, 0); chk("R7 pc", pc, 24'h5000);
    rreg(7'd127, v); chk("R7 user pc", v, u_exp);
    issue(10'h022, 7'd0, 7'd0, 24'h0); chk("R10 sup pc", pc, 24'h5001);
    rreg(7'd127, v); chk("R9 in sup", v, u_exp);
    irq = 1'b1; cyc(); irq = 1'b0;
    chk("R11 irq in sup mode", mode, 2); chk("R11 irq in sup pc", pc, 24'h5001);
    // extracode from supervisor, chained return
    issue(10'h207, 7'd0, 7'd0, 24'h0); chk("R3 from sup", pc, vec(7));
    rreg(7'd125, v); chk("R5 sup return point", v, 24'h5002);
    do_ret(); chk("R6 to sup mode", mode, 2); chk("R6 to sup pc", pc, 24'h5002);
    do_ret(); chk("R8 to user mode", mode, 0); chk("R8 to user pc", pc, u_exp);
    // R8 interrupt inside an extracode routine
    issue(10'h20A, 7'd0, 7'd0, 24'h0); u_exp = u_exp + 1;
    irq = 1'b1; cyc(); irq = 1'b0; chk("R7 irq from xc", mode, 2);
    do_ret(); chk("R8 back to xc", mode, 1); chk("R8 xc pc", pc, vec(10));
    do_ret(); chk("R6 final", pc, u_exp);
    // R4 wrap
    wreg(7'd5, 24'd2); issue(10'h201, 7'd0, 7'd5, 24'hFFFFFF); u_exp = u_exp + 1;
    chk("R4 wrap", xc_opnd, 24'd1); do_ret();
    // R11 return in user mode
    do_ret(); chk("R11 ret in user mode", mode, 0); chk("R11 ret in user pc", pc, u_exp);
    finish_run();
  end
endmodule